// File: doc/BRIEF.md
# I2C Target Port with 7/10-bit Address Recognition

This block is the target (slave) side of an I2C bus for a chip that has its own bus master. It watches SDA and SCL through synchroniser flops and finds START and STOP conditions. It then checks the address byte or bytes against a 10-bit own-address input. A configuration pin chooses 7-bit matching, which uses the low seven address bits, or 10-bit matching. In 10-bit mode a write header plus a low address byte opens the port. The port stays open until the next STOP, so a repeated START followed by a read header alone is enough to turn the transfer around.

Bytes the master writes pass through a shift register into a one-entry receive holding register. The host side sees that register as a valid/ready stream. Bytes the master reads come from a single transmit register that the host fills through its own valid/ready stream. There is no second stage: the shifter loads directly from that register.

When stretching is enabled, the port holds SCL low after the acknowledge of every byte. It lets SCL go when the host pulses a release pin. Both bus wires are open-drain. Each is modelled as a sampled input plus an output-enable that pulls the wire low.

Stream rules. `rx_valid` rises with a new byte and stays high, with `rx_data` frozen, until a cycle in which `rx_ready` is high. If a byte completes on the bus while the holding register is still full and not being popped in that same cycle, the port NACKs the byte and sets the overflow flag. A pop and a completing byte in the same cycle are both served. `tx_ready` is high while the transmit register is empty. A beat is taken when `tx_valid` and `tx_ready` are both high.

Top module: `i2c_tenbit_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `rx_irq` and every status output are 0, and `tx_ready` is 1.
- R2: With `cfg_ten_bit`=0, an address byte whose upper seven bits (bits 7..1) equal `cfg_own_addr[6:0]` is ACKed (SDA pulled low in the ninth clock). Any other address byte is NACKed, and the port ignores the rest of that transfer: no data reaches `rx_valid` and SDA is not driven.
- R3: With `cfg_ten_bit`=1, the port ACKs a first byte `11110`,`cfg_own_addr[9:8]`,0 and then a second byte equal to `cfg_own_addr[7:0]`. A mismatch in either byte is NACKed and the transfer is ignored.
- R4: In 10-bit mode, after a full write-address match and with no STOP in between, a repeated START followed by the read header `11110`,`cfg_own_addr[9:8]`,1 is ACKed and starts a read. Without that earlier match, the same read header is NACKed.
- R5: Each data byte written by the master and ACKed appears on `rx_data` with `rx_valid`, and `rx_irq` pulses for exactly one cycle as it arrives.
- R6: A data byte that completes while `rx_valid` is high and `rx_ready` is low is NACKed. It sets `sts_overflow` and leaves `rx_data` unchanged. `sts_overflow` clears at the next START.
- R7: On a read, bytes leave MSB first from the transmit register, and the register reads as empty (`tx_ready`=1) once it has been loaded into the shifter. If the register is empty when a byte starts, 0xFF is sent.
- R8: A master NACK after a read byte ends the transfer. SDA is released, and further clocks read back as all ones until a new START.
- R9: With `cfg_stretch_en`=1, `scl_oe` rises after the acknowledge clock of every accepted byte and stays high until a cycle with `scl_release`=1. With `cfg_stretch_en`=0, `scl_oe` never rises.
- R10: `sts_rw` holds the R/W bit of the last accepted address byte. `sts_addr` is 1 when the last accepted byte was an address byte and 0 when it was a data byte. `sts_full` follows `rx_valid`.
- R11: A STOP returns the port to idle and forgets an earlier 10-bit match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL wire |
| scl_oe | output | 1 | Pulls SCL low while 1 (stretching) |
| sda_i | input | 1 | Sampled SDA wire |
| sda_oe | output | 1 | Pulls SDA low while 1 |
| cfg_ten_bit | input | 1 | 1 selects 10-bit address matching |
| cfg_own_addr | input | 10 | Own address; 7-bit mode uses bits 6..0 |
| cfg_stretch_en | input | 1 | Hold SCL low after each accepted byte |
| scl_release | input | 1 | Pulse to let a stretched SCL go |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is waiting |
| rx_ready | input | 1 | Host takes the received byte |
| rx_irq | output | 1 | One-cycle pulse per stored byte |
| tx_data | input | 8 | Byte for the next read |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit register is empty |
| sts_rw | output | 1 | Direction of the current transfer, 1 = read |
| sts_addr | output | 1 | Last accepted byte was an address |
| sts_full | output | 1 | Receive register holds unread data |
| sts_overflow | output | 1 | A byte was refused for lack of room |

## Verification
Two functions can fall in the same clock cycle: the host popping the receive register, and the bus completing the next byte that must be stored there. The bench provokes the overlap by sweeping the cycle at which a single `rx_ready` pulse is given, across a window around the eighth SCL rise of the second byte, so that one offset lands exactly on the completion cycle. Each offset is judged for consistency, not against a guessed cycle. An ACKed byte must leave `sts_overflow` clear and appear as the next `rx_data`. A NACKed byte must set `sts_overflow` and leave the register empty after the pop. The sweep must produce both outcomes.

// File: rtl/i2c_ts_pkg.sv
package i2c_ts_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LOW,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_addr_check.sv
module i2c_addr_check
  import i2c_ts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              seven_hit,
  output logic              hdr_hit,
  output logic              low_hit
);

  localparam int HI_W = ADDR_W - BYTE_W;

  assign seven_hit = (byte_in[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
  assign hdr_hit   = (byte_in[BYTE_W-1:3] == TEN_PREFIX) &&
                     (byte_in[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);
  assign low_hit   = (byte_in == own_addr[BYTE_W-1:0]);

endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         room
);

  // a pop in the same cycle frees the slot for the incoming byte
  assign room = ~valid | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (valid && pop) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_tenbit_slave.sv
module i2c_tenbit_slave
  import i2c_ts_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cfg_ten_bit,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_stretch_en,
  input  logic              scl_release,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_irq,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sts_rw,
  output logic              sts_addr,
  output logic              sts_full,
  output logic              sts_overflow
);

  localparam int SLOT_W = $clog2(BYTE_W + 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] SLOT_ACK  = SLOT_W'(BYTE_W);
  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic seven_hit, hdr_hit, low_hit, room, push;
  logic [BYTE_W-1:0] byte_now, load_val;
  logic byte_end;

  phase_t            phase;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] shreg, tx_reg;
  logic ack_q, sda_oe_q, hold_q, ten_seen, rw_q, addr_q, ovf_q, irq_q, tx_full;

  i2c_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_check #(.ADDR_W(ADDR_W)) u_match (
    .byte_in(byte_now), .own_addr(cfg_own_addr),
    .seven_hit(seven_hit), .hdr_hit(hdr_hit), .low_hit(low_hit)
  );

  i2c_rx_hold #(.W(BYTE_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(byte_now),
    .pop(rx_ready), .valid(rx_valid), .data(rx_data), .room(room)
  );

  assign byte_now = {shreg[BYTE_W-2:0], sda_s};
  assign byte_end = (phase != PH_IDLE) && !start_det && !stop_det &&
                    scl_rise && (slot == SLOT_LAST);
  assign push     = byte_end && (phase == PH_WR) && room;
  assign load_val = tx_full ? tx_reg : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      slot     <= '0;
      shreg    <= '0;
      ack_q    <= 1'b0;
      sda_oe_q <= 1'b0;
      hold_q   <= 1'b0;
      ten_seen <= 1'b0;
      rw_q     <= 1'b0;
      addr_q   <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      tx_reg   <= '0;
      tx_full  <= 1'b0;
    end else begin
      irq_q <= push;
      if (hold_q && scl_release) hold_q <= 1'b0;

      if (stop_det) begin
        phase    <= PH_IDLE;
        ten_seen <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (start_det) begin
        phase    <= PH_HDR;
        slot     <= '0;
        sda_oe_q <= 1'b0;
        ack_q    <= 1'b0;
        ovf_q    <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (slot < SLOT_ACK) begin
            shreg <= byte_now;
            slot  <= slot + 1'b1;
          end else if (slot == SLOT_ACK) begin
            slot <= SLOT_END;
            // master NACK on a read byte ends the transfer
            if (phase == PH_RD && sda_s) phase <= PH_IDLE;
          end
          if (byte_end) begin
            ack_q <= 1'b0;
            unique case (phase)
              PH_HDR: begin
                if (!cfg_ten_bit) begin
                  if (seven_hit) begin
                    ack_q  <= 1'b1;
                    rw_q   <= byte_now[0];
                    addr_q <= 1'b1;
                    phase  <= byte_now[0] ? PH_RD : PH_WR;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end else if (hdr_hit && !byte_now[0]) begin
                  ack_q    <= 1'b1;
                  rw_q     <= 1'b0;
                  addr_q   <= 1'b1;
                  ten_seen <= 1'b0;
                  phase    <= PH_LOW;
                end else if (hdr_hit && ten_seen) begin
                  ack_q  <= 1'b1;
                  rw_q   <= 1'b1;
                  addr_q <= 1'b1;
                  phase  <= PH_RD;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_LOW: begin
                if (low_hit) begin
                  ack_q    <= 1'b1;
                  ten_seen <= 1'b1;
                  addr_q   <= 1'b1;
                  phase    <= PH_WR;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_WR: begin
                if (room) begin
                  ack_q  <= 1'b1;
                  addr_q <= 1'b0;
                end else begin
                  ovf_q <= 1'b1;
                end
              end
              PH_RD: addr_q <= 1'b0;
              default: phase <= PH_IDLE;
            endcase
          end
        end else if (scl_fall) begin
          if (slot == SLOT_ACK) begin
            sda_oe_q <= ack_q;
          end else if (slot == SLOT_END) begin
            slot     <= '0;
            sda_oe_q <= 1'b0;
            if (cfg_stretch_en) hold_q <= 1'b1;
            if (phase == PH_RD) begin
              shreg    <= load_val;
              sda_oe_q <= ~load_val[BYTE_W-1];
              tx_full  <= 1'b0;
            end
          end else if (phase == PH_RD) begin
            sda_oe_q <= ~shreg[BYTE_W-1];
          end
        end
      end

      // host write wins over a load in the same cycle
      if (tx_valid && !tx_full) begin
        tx_reg  <= tx_data;
        tx_full <= 1'b1;
      end
    end
  end

  assign scl_oe       = hold_q;
  assign sda_oe       = sda_oe_q;
  assign rx_irq       = irq_q;
  assign tx_ready     = ~tx_full;
  assign sts_rw       = rw_q;
  assign sts_addr     = addr_q;
  assign sts_full     = rx_valid;
  assign sts_overflow = ovf_q;

endmodule

// File: rtl/i2c_tenbit_slave_chk.sv
module i2c_tenbit_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_irq,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       scl_oe,
  input logic       scl_release,
  input logic       cfg_stretch_en,
  input logic       sts_overflow
);

  // R5
  irq_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R6
  rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_overflow) |-> rx_valid);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe && !scl_release |=> scl_oe);

  // R9
  hold_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(cfg_stretch_en));

  // R7
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

endmodule

bind i2c_tenbit_slave i2c_tenbit_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_irq(rx_irq), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .scl_oe(scl_oe), .scl_release(scl_release),
  .cfg_stretch_en(cfg_stretch_en), .sts_overflow(sts_overflow)
);

// File: tb/i2c_tenbit_slave_test.sv
module i2c_tenbit_slave_test;

  localparam int H = 8;
  localparam logic [9:0] OWN = 10'h2B5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic cfg_ten_bit = 1'b0, cfg_stretch_en = 1'b0, scl_release = 1'b0;
  logic [9:0] cfg_own_addr = OWN;
  logic [7:0] rx_data, tx_data = '0;
  logic rx_valid, rx_ready = 1'b0, rx_irq, tx_valid = 1'b0, tx_ready;
  logic sts_rw, sts_addr, sts_full, sts_overflow;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;

  i2c_tenbit_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_oe(sda_oe), .cfg_ten_bit(cfg_ten_bit),
    .cfg_own_addr(cfg_own_addr), .cfg_stretch_en(cfg_stretch_en),
    .scl_release(scl_release), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .sts_rw(sts_rw),
    .sts_addr(sts_addr), .sts_full(sts_full), .sts_overflow(sts_overflow)
  );

  int checks = 0, fails = 0, irq_cnt = 0, rise_no = 0;
  bit stray_hold = 0;

  always @(posedge clk) begin
    if (rx_irq) irq_cnt++;
    if (rst_n && scl_oe && !cfg_stretch_en) stray_hold = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; wait_scl_high(); tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H/2);
    m_scl = 1'b1; wait_scl_high(); tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(H/2);
    m_scl = 1'b1; rise_no++; wait_scl_high(); tick(H);
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(H/2);
    m_scl = 1'b1; rise_no++; wait_scl_high(); tick(H-2);
    b = sda_line; tick(2);
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    acked = ~x;
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      d[i] = x;
    end
    put_bit(~m_ack);
  endtask

  task automatic host_pop(output logic [7:0] d);
    d = rx_data;
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1; tick(1); tx_valid = 1'b0;
  endtask

  function automatic logic [7:0] hdr10(input logic rw);
    return {5'b11110, OWN[9:8], rw};
  endfunction

  function automatic logic [7:0] addr7(input logic rw);
    return {OWN[6:0], rw};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d, got, t1, t2;
    int seen_ack, seen_nack, irq0;
    void'($urandom(32'd7731));
    tick(5); rst_n = 1'b1; tick(2);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 status", {sts_rw, sts_addr, sts_full, sts_overflow}, 0);

    // R2 R5 R10: 7-bit write of random bytes
    bus_start();
    send_byte(addr7(1'b0), ack);
    chk("R2 own 7-bit address ack", ack, 1);
    chk("R10 addr flag", sts_addr, 1);
    chk("R10 rw write", sts_rw, 0);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      irq0 = irq_cnt;
      send_byte(d, ack);
      chk("R5 data ack", ack, 1);
      chk("R5 rx_data", rx_data, d);
      chk("R5 irq count", irq_cnt - irq0, 1);
      chk("R10 full/addr", {sts_full, sts_addr}, 2'b10);
      host_pop(got);
      chk("R5 popped empty", rx_valid, 0);
    end
    bus_stop();

    // R2 foreign address ignored
    bus_start();
    send_byte({OWN[6:1], ~OWN[0], 1'b0}, ack);
    chk("R2 foreign address nack", ack, 0);
    send_byte(8'h00, ack);
    chk("R2 ignored data nack", ack, 0);
    chk("R2 nothing stored", rx_valid, 0);
    bus_stop();

    // R6 overflow
    bus_start();
    send_byte(addr7(1'b0), ack);
    t1 = 8'($urandom); t2 = ~t1;
    send_byte(t1, ack);
    send_byte(t2, ack);
    chk("R6 overflow nack", ack, 0);
    chk("R6 overflow flag", sts_overflow, 1);
    chk("R6 data kept", rx_data, t1);
    bus_stop();
    bus_start();
    chk("R6 cleared at start", sts_overflow, 0);
    send_byte(addr7(1'b0), ack);
    host_pop(got);
    bus_stop();

    // R7 R8 R10: 7-bit read
    t1 = 8'($urandom); t2 = 8'($urandom);
    tx_push(t1);
    chk("R7 register full", tx_ready, 0);
    bus_start();
    send_byte(addr7(1'b1), ack);
    chk("R2 read address ack", ack, 1);
    chk("R10 rw read", sts_rw, 1);
    chk("R7 loaded leaves empty", tx_ready, 1);
    tx_push(t2);
    read_byte(1'b1, got);
    chk("R7 first byte", got, t1);
    read_byte(1'b1, got);
    chk("R7 second byte", got, t2);
    read_byte(1'b0, got);
    chk("R7 empty register sends ff", got, 8'hFF);
    read_byte(1'b0, got);
    chk("R8 released after nack", got, 8'hFF);
    chk("R8 sda idle", sda_oe, 0);
    bus_stop();

    // R3 R4 R11: 10-bit mode
    cfg_ten_bit = 1'b1;
    bus_start();
    send_byte(hdr10(1'b0), ack);
    chk("R3 header ack", ack, 1);
    send_byte(OWN[7:0], ack);
    chk("R3 low byte ack", ack, 1);
    d = 8'($urandom);
    send_byte(d, ack);
    chk("R3 data after match", rx_data, d);
    host_pop(got);
    t1 = 8'($urandom);
    tx_push(t1);
    bus_start();
    send_byte(hdr10(1'b1), ack);
    chk("R4 repeated start read header ack", ack, 1);
    chk("R4 direction read", sts_rw, 1);
    read_byte(1'b0, got);
    chk("R4 read data", got, t1);
    bus_stop();
    bus_start();
    send_byte(hdr10(1'b1), ack);
    chk("R11 match forgotten after stop", ack, 0);
    bus_stop();
    bus_start();
    send_byte(hdr10(1'b0), ack);
    send_byte(OWN[7:0] ^ 8'h01, ack);
    chk("R3 low byte mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte({5'b11110, ~OWN[9:8], 1'b0}, ack);
    chk("R3 header mismatch nack", ack, 0);
    bus_stop();
    chk("R9 no hold while disabled", int'(stray_hold), 0);

    // R9 stretching
    cfg_ten_bit = 1'b0;
    cfg_stretch_en = 1'b1;
    d = 8'($urandom);
    fork
      begin
        bus_start();
        send_byte(addr7(1'b0), ack);
        send_byte(d, ack);
        bus_stop();
      end
      begin
        for (int n = 0; n < 2; n++) begin
          int held;
          held = 0;
          wait (scl_oe);
          for (int c = 0; c < 20; c++) begin
            tick(1);
            if (scl_oe && !scl_line) held++;
          end
          chk("R9 scl held until release", held, 20);
          scl_release = 1'b1; tick(1); scl_release = 1'b0;
          tick(1);
          chk("R9 released", scl_oe, 0);
        end
      end
    join
    chk("R9 data through stretch", rx_data, d);
    host_pop(got);
    cfg_stretch_en = 1'b0;

    // R5 R6 pop and completion in the same cycle
    seen_ack = 0; seen_nack = 0;
    for (int off = 0; off < 6; off++) begin
      int r0;
      t1 = 8'($urandom); t2 = 8'($urandom);
      bus_start();
      send_byte(addr7(1'b0), ack);
      send_byte(t1, ack);
      r0 = rise_no;
      fork
        send_byte(t2, ack);
        begin
          wait (rise_no == r0 + 8);
          tick(off);
          host_pop(got);
        end
      join
      chk("R6 pop collision: first byte", got, t1);
      chk("R6 pop collision: ack vs overflow", int'(ack), int'(!sts_overflow));
      if (ack) begin
        seen_ack++;
        chk("R5 pop collision: kept byte", rx_data, t2);
        host_pop(got);
      end else begin
        seen_nack++;
        chk("R6 pop collision: empty", rx_valid, 0);
      end
      bus_stop();
    end
    chk("R6 sweep hit both outcomes", int'(seen_ack > 0 && seen_nack > 0), 1);

    finish_run();
  end

endmodule